// File: doc/BRIEF.md
# Indexed Indirect Effective-Address Resolver

This block turns a 25-bit instruction word into the final operand address of a word-addressed machine with 15-bit addresses. It adds the contents of a chosen base register to the displacement carried in the instruction. When the instruction asks for indirection, the block reads a word from memory at that address. It then reads that word as the next link of an address chain.

Each link is one of two kinds. An indirect link names its own base register and a 15-bit address, and it can ask for one more level. A field-selector link ends the chain. It yields an address and a pair of bit bounds that are stored with a bias of 3. The block holds the index (base) registers and has a write port to load them. A start/done handshake hands one instruction in at a time, and a request/valid port performs one memory read at a time.

Bit numbers below are 0-based, so bit 24 is the most significant bit of a 25-bit word.

Top module: `ea_resolver`

## Requirements
- R1: With instruction bit 24 clear, a start accepted while idle gives `done` on the next cycle. No memory read is made. `ea_addr` = (base + instr[9:0]) mod 2^15, and `field_valid`, `field_error` and `loop_error` are all 0.
- R2: The base is selected by bits 23:20 of the instruction or of the current link. A selector value of 0 contributes zero, and values 1 to 15 select index registers 1 to 15.
- R3: When `idx_we` is high at a clock edge, register `idx_sel` takes `idx_wdata`, and later address sums use the new value. A write to selector 0 has no effect.
- R4: With instruction bit 24 set, the block sends exactly one `rd_req` pulse, with `rd_addr` equal to the base-plus-displacement sum. It then waits, busy and with no further request, for as many cycles as `rd_valid` stays low.
- R5: A returned word whose bits 19:17 are all zero is an indirect link, and its next address is (base + word[14:0]) mod 2^15. If its bit 24 is set, the block reads that address. If bit 24 is clear, the block finishes with that address and `field_valid` = 0.
- R6: Any other returned word is a field selector and ends the chain, whatever its bit 24 holds. Its outputs are `ea_addr` = (base + word[9:0]) mod 2^15, `left_pos` = (word[19:15] − 3) mod 32, `right_pos` = (word[14:10] − 3) mod 32, and `field_valid` = 1.
- R7: `field_error` is set with a field selector when either decoded position falls outside 1 to 24, or when the left position is below the right position.
- R8: At most 16 reads are made per instruction. If a 16th link still asks to continue, the block finishes with `loop_error` = 1 and `ea_addr` set to the address that would have been read next.
- R9: `start` is ignored while `busy` is high. The chain in progress completes unchanged, and only one `done` is produced.
- R10: `done` is a one-cycle pulse given as the block returns to idle. The result outputs change only with `done` and hold their values until the next `done`.
- R11: After reset, `busy`, `done` and `rd_req` are low, all result outputs are zero, and all index registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `instr` (taken only when idle) |
| instr | input | 25 | Instruction word |
| busy | output | 1 | A chain is being resolved |
| done | output | 1 | One-cycle pulse: result outputs are updated |
| ea_addr | output | 15 | Resolved operand address |
| field_valid | output | 1 | Chain ended in a field selector |
| left_pos | output | 5 | Decoded left bit bound |
| right_pos | output | 5 | Decoded right bit bound |
| field_error | output | 1 | Field bounds out of range or reversed |
| loop_error | output | 1 | Indirection depth limit exceeded |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 15 | Memory read address |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 25 | Read data word |
| idx_we | input | 1 | Index register write enable |
| idx_sel | input | 4 | Index register to write |
| idx_wdata | input | 15 | Index register write data |

## Verification
Direct instructions are swept over every base selector with registers preloaded so that the sums wrap. This separates a wrong register choice, a missing selector-0 rule and a missing modulo. Field selectors are swept over every left code from 4 to 31 against every right code, which maps each edge of the range rule and of the ordering rule. Chains of one, three, exactly sixteen and endless links separate the link decode, the depth limit and the loop stop. A delayed response and a start issued mid-chain show that the block waits and that a start while busy is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W    = 25;
    localparam int XSEL_W    = 4;
    localparam int DISP_W    = 10;
    localparam int POS_W     = 5;
    localparam int LINK_W    = 15;
    // fixed bit positions of the word layouts (0-based)
    localparam int FLAG_BIT  = 24;
    localparam int XSEL_LSB  = 20;
    localparam int ZERO_LSB  = 17;
    localparam int ZERO_W    = 3;
    localparam int LEFT_LSB  = 15;
    localparam int RIGHT_LSB = 10;
    // bit-bound coding
    localparam int POS_BIAS  = 3;
    localparam int POS_LO    = 1;
    localparam int POS_HI    = 24;

    typedef enum logic [0:0] {
        WALK_IDLE = 1'b0,
        WALK_WAIT = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic [LINK_W-1:0] addr;
        logic              field_valid;
        logic [POS_W-1:0]  left;
        logic [POS_W-1:0]  right;
        logic              field_error;
        logic              loop_error;
    } ea_result_t;

    function automatic logic [XSEL_W-1:0] word_xsel(input logic [WORD_W-1:0] w);
        return w[XSEL_LSB +: XSEL_W];
    endfunction

    function automatic logic word_flag(input logic [WORD_W-1:0] w);
        return w[FLAG_BIT];
    endfunction

    function automatic logic is_link_form(input logic [WORD_W-1:0] w);
        return w[ZERO_LSB +: ZERO_W] == '0;
    endfunction
endpackage

// File: rtl/ea_index_file.sv
module ea_index_file
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int NUM_IDX = 15,
    parameter int SEL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel,
    output logic [ADDR_W-1:0] rdata
);
    logic [ADDR_W-1:0] regs [1:NUM_IDX];

    for (genvar g = 1; g <= NUM_IDX; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wsel == SEL_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 1; k <= NUM_IDX; k++) begin
            if (rsel == SEL_W'(k)) begin
                rdata = regs[k];
            end
        end
    end
endmodule

// File: rtl/ea_addr_sum.sv
module ea_addr_sum #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] sum
);
    // wraps modulo 2^ADDR_W by width
    assign sum = base + offset;
endmodule

// File: rtl/ea_field_decode.sv
module ea_field_decode
    import ea_pkg::*;
(
    input  logic [POS_W-1:0] raw_left,
    input  logic [POS_W-1:0] raw_right,
    output logic [POS_W-1:0] left,
    output logic [POS_W-1:0] right,
    output logic             bad
);
    localparam logic [POS_W-1:0] RAW_MIN = POS_W'(POS_LO + POS_BIAS);
    localparam logic [POS_W-1:0] RAW_MAX = POS_W'(POS_HI + POS_BIAS);

    logic left_ok, right_ok;

    assign left     = raw_left  - POS_W'(POS_BIAS);
    assign right    = raw_right - POS_W'(POS_BIAS);
    assign left_ok  = (raw_left  >= RAW_MIN) && (raw_left  <= RAW_MAX);
    assign right_ok = (raw_right >= RAW_MIN) && (raw_right <= RAW_MAX);
    // same bias on both sides, so raw order equals decoded order
    assign bad      = !left_ok || !right_ok || (raw_left < raw_right);
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_IDX   = 15,
    parameter int MAX_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   instr,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   ea_addr,
    output logic                field_valid,
    output logic [POS_W-1:0]    left_pos,
    output logic [POS_W-1:0]    right_pos,
    output logic                field_error,
    output logic                loop_error,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_valid,
    input  logic [WORD_W-1:0]   rd_data,
    input  logic                idx_we,
    input  logic [XSEL_W-1:0]   idx_sel,
    input  logic [ADDR_W-1:0]   idx_wdata
);
    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

    walk_state_e        state;
    logic [DEPTH_W-1:0] depth;
    ea_result_t         res;

    logic [XSEL_W-1:0]  base_sel;
    logic [ADDR_W-1:0]  base_val;
    logic [ADDR_W-1:0]  offset;
    logic [ADDR_W-1:0]  sum;
    logic               link_form;
    logic               link_more;
    logic [POS_W-1:0]   dec_left, dec_right;
    logic               dec_bad;
    logic               unused_bits;

    assign unused_bits = ^{instr[XSEL_LSB-1:DISP_W], rd_data[LEFT_LSB+1:LEFT_LSB]};

    assign link_form = is_link_form(rd_data);
    assign link_more = link_form && word_flag(rd_data);

    // one shared base read and adder serve the instruction and every link
    always_comb begin
        if (state == WALK_IDLE) begin
            base_sel = word_xsel(instr);
            offset   = ADDR_W'(instr[DISP_W-1:0]);
        end else begin
            base_sel = word_xsel(rd_data);
            offset   = link_form ? ADDR_W'(rd_data[LINK_W-1:0])
                                 : ADDR_W'(rd_data[DISP_W-1:0]);
        end
    end

    ea_index_file #(
        .ADDR_W  (ADDR_W),
        .NUM_IDX (NUM_IDX),
        .SEL_W   (XSEL_W)
    ) u_idx (
        .clk   (clk),
        .rst   (rst),
        .we    (idx_we),
        .wsel  (idx_sel),
        .wdata (idx_wdata),
        .rsel  (base_sel),
        .rdata (base_val)
    );

    ea_addr_sum #(
        .ADDR_W (ADDR_W)
    ) u_sum (
        .base   (base_val),
        .offset (offset),
        .sum    (sum)
    );

    ea_field_decode u_fdec (
        .raw_left  (rd_data[LEFT_LSB  +: POS_W]),
        .raw_right (rd_data[RIGHT_LSB +: POS_W]),
        .left      (dec_left),
        .right     (dec_right),
        .bad       (dec_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WALK_IDLE;
            depth   <= '0;
            rd_req  <= 1'b0;
            rd_addr <= '0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            rd_req <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                WALK_IDLE: begin
                    if (start) begin
                        if (word_flag(instr)) begin
                            rd_req  <= 1'b1;
                            rd_addr <= sum;
                            depth   <= DEPTH_W'(1);
                            state   <= WALK_WAIT;
                        end else begin
                            res      <= '0;
                            res.addr <= sum;
                            done     <= 1'b1;
                        end
                    end
                end
                WALK_WAIT: begin
                    if (rd_valid) begin
                        if (link_more) begin
                            if (depth == DEPTH_W'(MAX_DEPTH)) begin
                                res            <= '0;
                                res.addr       <= sum;
                                res.loop_error <= 1'b1;
                                done           <= 1'b1;
                                state          <= WALK_IDLE;
                            end else begin
                                rd_req  <= 1'b1;
                                rd_addr <= sum;
                                depth   <= depth + DEPTH_W'(1);
                            end
                        end else if (link_form) begin
                            res      <= '0;
                            res.addr <= sum;
                            done     <= 1'b1;
                            state    <= WALK_IDLE;
                        end else begin
                            res.addr        <= sum;
                            res.field_valid <= 1'b1;
                            res.left        <= dec_left;
                            res.right       <= dec_right;
                            res.field_error <= dec_bad;
                            res.loop_error  <= 1'b0;
                            done            <= 1'b1;
                            state           <= WALK_IDLE;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    assign busy        = (state != WALK_IDLE);
    assign ea_addr     = res.addr;
    assign field_valid = res.field_valid;
    assign left_pos    = res.left;
    assign right_pos   = res.right;
    assign field_error = res.field_error;
    assign loop_error  = res.loop_error;
endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk #(
    parameter int ADDR_W    = 15,
    parameter int MAX_DEPTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] ea_addr,
    input logic              field_valid,
    input logic              field_error,
    input logic              loop_error,
    input logic              rd_req,
    input logic              rd_valid
);
    int unsigned reads_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            reads_seen <= 0;
        end else if (start && !busy) begin
            reads_seen <= 0;
        end else if (rd_req) begin
            reads_seen <= reads_seen + 1;
        end
    end

    p_req_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy);

    p_req_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> ($past(rd_valid) || $past(start)));

    p_wait_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_valid) |=> (busy && !rd_req && !done));

    p_done_to_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && ($past(busy) || $past(start))));

    p_result_held_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ea_addr));

    p_ferr_only_field_r7: assert property (@(posedge clk) disable iff (rst)
        field_error |-> field_valid);

    p_loop_no_field_r8: assert property (@(posedge clk) disable iff (rst)
        loop_error |-> !field_valid);

    p_depth_cap_r8: assert property (@(posedge clk) disable iff (rst)
        reads_seen <= MAX_DEPTH);
endmodule

bind ea_resolver ea_resolver_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_DEPTH (MAX_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .ea_addr     (ea_addr),
    .field_valid (field_valid),
    .field_error (field_error),
    .loop_error  (loop_error),
    .rd_req      (rd_req),
    .rd_valid    (rd_valid)
);

// File: tb/ea_resolver_test.sv
module ea_resolver_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [24:0] instr = '0;
    logic        busy, done;
    logic [14:0] ea_addr;
    logic        field_valid;
    logic [4:0]  left_pos, right_pos;
    logic        field_error, loop_error;
    logic        rd_req;
    logic [14:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [24:0] rd_data = '0;
    logic        idx_we = 1'b0;
    logic [3:0]  idx_sel = '0;
    logic [14:0] idx_wdata = '0;

    always #2 clk = ~clk;

    ea_resolver uut (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .busy(busy), .done(done), .ea_addr(ea_addr),
        .field_valid(field_valid), .left_pos(left_pos), .right_pos(right_pos),
        .field_error(field_error), .loop_error(loop_error),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .idx_we(idx_we), .idx_sel(idx_sel), .idx_wdata(idx_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [24:0] mem [0:255];
    logic [14:0] model_idx [0:15];

    int          r_reads, r_cycles, r_dones;
    logic [14:0] r_ea, r_last;
    logic        r_fv, r_fe, r_le;
    logic [4:0]  r_l, r_r;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [24:0] mk_ins(input bit f, input int x, input int d);
        return {f, 4'(x), 10'h2A5, 10'(d)};
    endfunction
    function automatic logic [24:0] mk_link(input bit f, input int x, input int a);
        return {f, 4'(x), 3'b000, 2'b11, 15'(a)};
    endfunction
    function automatic logic [24:0] mk_sel(input bit f, input int x, input int l,
                                           input int r, input int d);
        return {f, 4'(x), 5'(l), 5'(r), 10'(d)};
    endfunction

    task automatic wr_idx(input int s, input int v);
        @(negedge clk);
        idx_we = 1'b1; idx_sel = 4'(s); idx_wdata = 15'(v);
        @(negedge clk);
        idx_we = 1'b0;
        if (s != 0) model_idx[s] = 15'(v);
    endtask

    task automatic run(input logic [24:0] ins, input int lat);
        bit fin;
        fin = 0;
        r_reads = 0; r_cycles = 0; r_last = '0;
        @(negedge clk);
        start = 1'b1; instr = ins;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !fin; i++) begin
            r_cycles = r_cycles + 1;
            if (done) begin
                r_ea = ea_addr; r_fv = field_valid; r_fe = field_error;
                r_le = loop_error; r_l = left_pos; r_r = right_pos;
                fin = 1;
            end else begin
                if (rd_req) begin
                    r_reads = r_reads + 1;
                    r_last = rd_addr;
                    repeat (lat) @(negedge clk);
                    rd_valid = 1'b1;
                    rd_data = mem[r_last[7:0]];
                    @(negedge clk);
                    rd_valid = 1'b0;
                end else begin
                    @(negedge clk);
                end
            end
        end
        if (!fin) chk(0, "R4", "run never finished", 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = mk_link(1'b0, 0, 0);
        for (int i = 0; i < 16; i++) model_idx[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !rd_req, "R11", "control after reset",
            {busy, done, rd_req}, 0);
        chk(ea_addr == 0 && !field_valid && !field_error && !loop_error, "R11",
            "results after reset", ea_addr, 0);
        run(mk_ins(1'b0, 9, 321), 0);
        chk(r_ea == 15'd321, "R11", "index register zero after reset", r_ea, 321);

        // R3 write to selector 0 is ignored
        wr_idx(0, 555);
        run(mk_ins(1'b0, 0, 7), 0);
        chk(r_ea == 15'd7, "R3", "selector 0 write ignored", r_ea, 7);

        // R1 R2 R3: sweep every base selector with wrapping sums
        for (int k = 1; k < 16; k++) wr_idx(k, (k * 2187 + 30000) % 32768);
        for (int x = 0; x < 16; x++) begin
            for (int p = 0; p < 4; p++) begin
                int d;
                logic [14:0] e;
                d = (p == 0) ? 0 : (p == 1) ? 1023 : (p == 2) ? 512 : (x * 37) % 1024;
                e = 15'((int'(model_idx[x]) + d) % 32768);
                run(mk_ins(1'b0, x, d), 0);
                chk(r_ea == e, "R2", "direct base+disp", r_ea, e);
                chk(r_reads == 0 && r_cycles == 1 && !r_fv && !r_le && !r_fe,
                    "R1", "direct: no read, one cycle", r_cycles, 1);
            end
        end

        // R3 new value used after rewrite
        wr_idx(4, 32767);
        run(mk_ins(1'b0, 4, 3), 0);
        chk(r_ea == 15'd2, "R3", "rewritten register wraps", r_ea, 2);

        for (int k = 1; k < 16; k++) wr_idx(k, k * 4);

        // R4 R5 single link, plain end
        mem[18] = mk_link(1'b0, 3, 50);
        run(mk_ins(1'b1, 2, 10), 0);
        chk(r_reads == 1 && r_last == 15'd18, "R4", "single read address", r_last, 18);
        chk(r_ea == 15'd62 && !r_fv && !r_le, "R5", "link plain end", r_ea, 62);

        // R4 long latency wait
        run(mk_ins(1'b1, 2, 10), 25);
        chk(r_reads == 1 && r_ea == 15'd62, "R4", "waits for late data", r_reads, 1);

        // R5 R6 three-link chain ending in a selector
        mem[20] = mk_link(1'b1, 0, 30);
        mem[30] = mk_link(1'b1, 1, 36);
        mem[40] = mk_sel(1'b1, 2, 23, 8, 100);
        run(mk_ins(1'b1, 0, 20), 1);
        chk(r_reads == 3 && r_last == 15'd40, "R5", "chain reads", r_reads, 3);
        chk(r_ea == 15'd108 && r_fv && !r_fe && r_l == 5'd20 && r_r == 5'd5,
            "R6", "selector end of chain", {r_ea, r_l, r_r}, {15'd108, 5'd20, 5'd5});

        // R6 R7 sweep of selector bound codes
        for (int l = 4; l < 32; l++) begin
            for (int r = 0; r < 32; r++) begin
                logic [4:0] el, er;
                bit eb;
                el = 5'(l - 3); er = 5'(r - 3);
                eb = (l < 4) || (l > 27) || (r < 4) || (r > 27) || (l < r);
                mem[5] = mk_sel(1'b0, 3, l, r, 9);
                run(mk_ins(1'b1, 0, 5), (l + r) % 3);
                chk(r_ea == 15'd21 && r_fv && !r_le && r_reads == 1, "R6",
                    "selector address", r_ea, 21);
                chk(r_l == el && r_r == er, "R6", "decoded bounds",
                    {r_l, r_r}, {el, er});
                chk(r_fe == eb, "R7", "bound error flag", r_fe, eb);
            end
        end

        // R8 exactly sixteen reads is allowed
        for (int i = 0; i < 15; i++) mem[100 + i] = mk_link(1'b1, 0, 101 + i);
        mem[115] = mk_link(1'b0, 0, 200);
        run(mk_ins(1'b1, 0, 100), 0);
        chk(r_reads == 16 && r_ea == 15'd200 && !r_le, "R8", "sixteen-read chain",
            r_reads, 16);

        // R8 endless chain stops with loop error
        mem[60] = mk_link(1'b1, 0, 60);
        run(mk_ins(1'b1, 0, 60), 0);
        chk(r_reads == 16 && r_le && !r_fv && r_ea == 15'd60, "R8", "loop stop",
            r_reads, 16);
        @(negedge clk);
        chk(!busy && !rd_req, "R8", "idle after loop stop", {busy, rd_req}, 0);

        // R9 R10 start while busy is ignored
        @(negedge clk);
        start = 1'b1; instr = mk_ins(1'b1, 2, 10);
        @(negedge clk);
        instr = mk_ins(1'b0, 0, 77);
        chk(busy && rd_req, "R4", "request after start", {busy, rd_req}, 3);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rd_valid = 1'b1; rd_data = mem[18];
        @(negedge clk);
        rd_valid = 1'b0;
        r_dones = 0;
        chk(done && ea_addr == 15'd62, "R9", "first chain result kept", ea_addr, 62);
        for (int i = 0; i < 6; i++) begin
            if (done) r_dones = r_dones + 1;
            @(negedge clk);
        end
        chk(r_dones == 1, "R10", "single done pulse", r_dones, 1);
        chk(ea_addr == 15'd62 && !busy, "R10", "result held", ea_addr, 62);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule